// File: doc/BRIEF.md
# Two-Wire Bus Target Controller

This block is the target (slave) side of a two-wire serial bus for a peripheral that sits behind a register interface. It watches the bus clock and data lines, which an external controller drives, and finds the START, repeated START and STOP conditions. After each START it collects a 7-bit address and a direction bit. If the address equals the programmed own address, the block acknowledges it and then either shifts received bytes into a receive register (controller writes) or shifts out bytes from a one-deep transmit holding register (controller reads).

The block never generates bus conditions and never drives the clock line, so it needs no clock-divider setting. It pulls the data line low only through an open-drain output enable. Software-side logic sees five flags. The access flag stays high for the whole addressed transaction. The direction flag gives the transfer direction. The end-of-access flag is a one-cycle pulse when an access closes. The transfer-complete flag is set when a read access ends. The underrun flag is set when a byte was needed but the holding register was empty. Before use, the own address must be set, controller operation must be disabled and target operation enabled.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset `sda_oe`, `acc`, `rd_dir`, `eoa`, `txcomp`, `underrun` and `rx_valid` are 0 and `tx_empty` is 1.
- R2: An address byte is sent MSB first, with the 7-bit address in its upper bits and the direction in bit 0 (1 = controller reads). When the address equals `own_addr`, the block pulls SDA low during the ninth clock, sets `acc`, and sets `rd_dir` to the direction bit.
- R3: A non-matching address is not acknowledged, `acc` stays 0, and all following bytes are neither acknowledged nor stored until the next START.
- R4: In a write access every data byte is acknowledged, copied to `rx_data`, and sets `rx_valid`. A one-cycle `rx_read` pulse clears `rx_valid`.
- R5: In a read access each byte comes from the holding register, MSB first. Taking a byte empties the register (`tx_empty` goes to 1), and a `tx_load` pulse fills it.
- R6: If the holding register is empty when a read byte is needed, the block sends 0xFF and sets `underrun`. The next matching address clears `underrun`.
- R7: After the controller does not acknowledge a read byte, the block drives SDA no more until the next START or STOP.
- R8: A STOP or repeated START during an access clears `acc` and raises `eoa` for exactly one cycle. Without an access, `eoa` stays low.
- R9: When a read access ends, `txcomp` is set. A write access leaves it unchanged, and the next matching address clears it.
- R10: While `slave_en` is 0 or `master_dis` is 0, the block acknowledges nothing, keeps `acc` low and releases SDA.
- R11: The block starts pulling SDA low only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| own_addr | input | 7 | Programmed own address |
| slave_en | input | 1 | Target operation enable |
| master_dis | input | 1 | Controller operation disabled (must be 1 for target use) |
| tx_data | input | 8 | Byte to place in the transmit holding register |
| tx_load | input | 1 | Write strobe for the holding register |
| tx_empty | output | 1 | Holding register is empty |
| rx_data | output | 8 | Last byte received in a write access |
| rx_valid | output | 1 | Receive-ready flag |
| rx_read | input | 1 | Clears the receive-ready flag |
| acc | output | 1 | Addressed access in progress |
| rd_dir | output | 1 | Direction of the current or last access (1 = read) |
| eoa | output | 1 | One-cycle pulse when an access ends |
| txcomp | output | 1 | Read transfer complete |
| underrun | output | 1 | A read byte was needed while the holding register was empty |

## Verification
Some rules are checked on every cycle by the bound checker. It checks that the end-of-access pulse lasts one cycle and comes only with a falling access flag, that transfer-complete rises only when a read access closes, that a disabled block holds the access flag low and leaves SDA released, and that SDA is pulled low only while SCL is low. Other behaviour can only be shown by the bench's bus scenarios, run against a behavioural model: address matching and the value of the acknowledge bit, the byte contents in both directions, the 0xFF underrun substitution, the release after a controller NACK, and the ignoring of bytes after a mismatched address.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_RNEXT,
      ST_HOLD
   } tgt_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_evt_t;

endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync
   import i2c_tgt_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt,
   output logic     scl_lvl
);

   logic [STAGES-1:0] scl_r;
   logic [STAGES-1:0] sda_r;
   logic              scl_p;
   logic              sda_p;
   logic              scl_s;
   logic              sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_r <= '1;
         sda_r <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_r <= {scl_r[STAGES-2:0], scl_i};
         sda_r <= {sda_r[STAGES-2:0], sda_i};
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_s = scl_r[STAGES-1];
   assign sda_s = sda_r[STAGES-1];

   always_comb begin
      evt.start = scl_s & scl_p & sda_p & ~sda_s;
      evt.stop  = scl_s & scl_p & ~sda_p & sda_s;
      evt.rise  = scl_s & ~scl_p;
      evt.fall  = ~scl_s & scl_p;
      evt.sda   = sda_s;
   end

   assign scl_lvl = scl_s;

endmodule

// File: rtl/i2c_tgt_txhold.sv
module i2c_tgt_txhold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_en,
   input  logic          take,
   output logic [DW-1:0] out_byte,
   output logic          empty
);

   logic [DW-1:0] hold_q;
   logic          full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (take) full_q <= 1'b0;
         if (wr_en) begin
            hold_q <= wr_data;
            full_q <= 1'b1;
         end
      end
   end

   assign out_byte = full_q ? hold_q : {DW{1'b1}};
   assign empty    = ~full_q;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int AW = 7,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bus_evt_t      evt,
   input  logic [AW-1:0] own_addr,
   input  logic          active,
   input  logic [DW-1:0] tx_byte,
   input  logic          tx_none,
   output logic          take,
   input  logic          rx_read,
   output logic [DW-1:0] rx_data,
   output logic          rx_valid,
   output logic          sda_oe,
   output logic          acc,
   output logic          rd_dir,
   output logic          eoa,
   output logic          txcomp,
   output logic          underrun
);

   localparam int CNT_W = $clog2(DW + 2);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

   tgt_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [DW-1:0]    sh;

   assign take = evt.fall &
                 (((state == ST_AACK) & sda_oe & rd_dir) | (state == ST_RNEXT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         sh       <= '0;
         sda_oe   <= 1'b0;
         acc      <= 1'b0;
         rd_dir   <= 1'b0;
         eoa      <= 1'b0;
         txcomp   <= 1'b0;
         underrun <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         eoa <= 1'b0;
         if (rx_read) rx_valid <= 1'b0;
         if (!active) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            acc    <= 1'b0;
         end else if (evt.start || evt.stop) begin
            if (acc) begin
               eoa <= 1'b1;
               acc <= 1'b0;
               if (rd_dir) txcomp <= 1'b1;
            end
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= evt.start ? ST_ADDR : ST_IDLE;
         end else begin
            if (take) begin
               sh     <= tx_byte;
               sda_oe <= ~tx_byte[DW-1];
               cnt    <= '0;
               state  <= ST_RDATA;
               if (tx_none) underrun <= 1'b1;
            end
            unique case (state)
               ST_ADDR: if (evt.rise) begin
                  sh  <= {sh[DW-2:0], evt.sda};
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST) begin
                     if (sh[AW-1:0] == own_addr) begin
                        acc      <= 1'b1;
                        rd_dir   <= evt.sda;
                        txcomp   <= 1'b0;
                        underrun <= 1'b0;
                        state    <= ST_AACK;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end
               end
               ST_AACK: if (evt.fall) begin
                  if (!sda_oe) begin
                     sda_oe <= 1'b1;
                  end else if (!rd_dir) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WDATA;
                  end
               end
               ST_WDATA: if (evt.rise) begin
                  sh  <= {sh[DW-2:0], evt.sda};
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST) begin
                     rx_data  <= {sh[DW-2:0], evt.sda};
                     rx_valid <= 1'b1;
                     state    <= ST_WACK;
                  end
               end
               ST_WACK: if (evt.fall) begin
                  if (!sda_oe) begin
                     sda_oe <= 1'b1;
                  end else begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (evt.rise && cnt != FULL) cnt <= cnt + 1'b1;
                  if (evt.fall) begin
                     if (cnt == FULL) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else if (cnt != '0) begin
                        sh     <= {sh[DW-2:0], 1'b0};
                        sda_oe <= ~sh[DW-2];
                     end
                  end
               end
               ST_RACK: if (evt.rise) begin
                  state <= evt.sda ? ST_HOLD : ST_RNEXT;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              slave_en,
   input  logic              master_dis,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   output logic              tx_empty,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_read,
   output logic              acc,
   output logic              rd_dir,
   output logic              eoa,
   output logic              txcomp,
   output logic              underrun
);

   if (ADDR_W != DATA_W - 1) begin : g_bad_addr_w
      $error("ADDR_W must be DATA_W-1 for the 7-bit address byte layout");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   bus_evt_t          evt;
   logic              scl_lvl;
   logic              take;
   logic [DATA_W-1:0] tx_byte;
   logic              active;

   assign active = slave_en & master_dis;

   i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .evt     (evt),
      .scl_lvl (scl_lvl)
   );

   i2c_tgt_txhold #(.DW(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (tx_data),
      .wr_en    (tx_load),
      .take     (take),
      .out_byte (tx_byte),
      .empty    (tx_empty)
   );

   i2c_tgt_engine #(.AW(ADDR_W), .DW(DATA_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .own_addr (own_addr),
      .active   (active),
      .tx_byte  (tx_byte),
      .tx_none  (tx_empty),
      .take     (take),
      .rx_read  (rx_read),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .sda_oe   (sda_oe),
      .acc      (acc),
      .rd_dir   (rd_dir),
      .eoa      (eoa),
      .txcomp   (txcomp),
      .underrun (underrun)
   );

endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic slave_en,
   input logic master_dis,
   input logic sda_oe,
   input logic acc,
   input logic rd_dir,
   input logic eoa,
   input logic txcomp
);

   AST_EOA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      eoa |=> !eoa); // R8

   AST_EOA_WITH_ACC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      eoa |-> $fell(acc)); // R8

   AST_TXCOMP_ON_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txcomp) |-> ($past(rd_dir) && $fell(acc))); // R9

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(slave_en && master_dis) |=> (!acc && !sda_oe)); // R10

   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_s)); // R11

endmodule

bind i2c_target_ctrl i2c_target_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_lvl),
   .slave_en   (slave_en),
   .master_dis (master_dis),
   .sda_oe     (sda_oe),
   .acc        (acc),
   .rd_dir     (rd_dir),
   .eoa        (eoa),
   .txcomp     (txcomp)
);

// File: tb/i2c_target_ctrl_bench.sv
module i2c_target_ctrl_bench;

   localparam int CLK_NS = 10;
   localparam int Q      = 8;
   localparam logic [6:0] OWN = 7'h3A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       bus_sda;
   logic       sda_oe;
   logic [6:0] own_addr = OWN;
   logic       slave_en = 1'b0;
   logic       master_dis = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_load = 1'b0;
   logic       tx_empty;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_read = 1'b0;
   logic       acc, rd_dir, eoa, txcomp, underrun;

   int n_chk = 0;
   int n_fail = 0;
   int eoa_cnt = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [7:0] mdl_hold[$];
   bit         mdl_acc, mdl_rd, mdl_txc, mdl_und;
   int         mdl_eoa = 0;

   assign bus_sda = m_sda & ~sda_oe;

   always #(CLK_NS/2) clk = ~clk;

   always @(posedge clk) if (eoa) eoa_cnt <= eoa_cnt + 1;

   i2c_target_ctrl u_i2c_target_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(sda_oe),
      .own_addr(own_addr), .slave_en(slave_en), .master_dis(master_dis),
      .tx_data(tx_data), .tx_load(tx_load), .tx_empty(tx_empty),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
      .acc(acc), .rd_dir(rd_dir), .eoa(eoa), .txcomp(txcomp), .underrun(underrun)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_flags(input string tag);
      check({tag, " acc"}, acc, mdl_acc);
      if (mdl_acc) check({tag, " rd_dir"}, rd_dir, mdl_rd);
      check({tag, " txcomp"}, txcomp, mdl_txc);
      check({tag, " underrun"}, underrun, mdl_und);
      check({tag, " eoa count"}, eoa_cnt, mdl_eoa);
   endtask

   task automatic bus_start();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b = bus_sda; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack_n);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(ack_n);
   endtask

   task automatic get_bits(output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         get_bit(b);
         v[i] = b;
      end
   endtask

   task automatic push_tx(input logic [7:0] v);
      tx_data = v; tx_load = 1'b1; tick(1);
      tx_load = 1'b0; tick(1);
      mdl_hold.push_back(v);
   endtask

   function automatic logic [7:0] mdl_take();
      if (mdl_hold.size() == 0) begin
         mdl_und = 1'b1;
         return 8'hFF;
      end
      return mdl_hold.pop_front();
   endfunction

   task automatic pulse_rx_read();
      rx_read = 1'b1; tick(1);
      rx_read = 1'b0; tick(1);
   endtask

   task automatic mdl_close();
      if (mdl_acc) begin
         mdl_eoa++;
         if (mdl_rd) mdl_txc = 1'b1;
         mdl_acc = 1'b0;
      end
   endtask

   task automatic mdl_match(input bit rd);
      mdl_acc = 1'b1; mdl_rd = rd; mdl_txc = 1'b0; mdl_und = 1'b0;
   endtask

   initial begin
      logic       a;
      logic [7:0] v;
      logic [7:0] e;
      tick(4);
      // R1 reset state
      check("R1 sda_oe", sda_oe, 0);
      check("R1 tx_empty", tx_empty, 1);
      check("R1 rx_valid", rx_valid, 0);
      check("R1 eoa", eoa, 0);
      check_flags("R1");
      rst_n = 1'b1;
      slave_en = 1'b1; master_dis = 1'b1;
      tick(4);

      // R2 R4 write access
      bus_start();
      put_byte({OWN, 1'b0}, a);
      check("R2 address ack", a, 0);
      mdl_match(0);
      check_flags("R2");
      put_byte(8'hA5, a);
      check("R4 data ack", a, 0);
      check("R4 rx_data", rx_data, 8'hA5);
      check("R4 rx_valid", rx_valid, 1);
      pulse_rx_read();
      check("R4 rx_valid cleared", rx_valid, 0);
      put_byte(8'h3C, a);
      check("R4 second ack", a, 0);
      check("R4 rx_data 2", rx_data, 8'h3C);
      bus_stop();
      mdl_close();
      check_flags("R8 R9 after write stop");
      pulse_rx_read();

      // R5 R7 R9 read access
      push_tx(8'h96);
      check("R5 tx_empty after load", tx_empty, 0);
      bus_start();
      put_byte({OWN, 1'b1}, a);
      check("R2 read address ack", a, 0);
      mdl_match(1);
      check_flags("R2 read");
      e = mdl_take();
      get_bits(v);
      check("R5 first byte", v, e);
      check("R5 tx_empty after take", tx_empty, 1);
      push_tx(8'h5B);
      put_bit(1'b0);
      e = mdl_take();
      get_bits(v);
      check("R5 second byte", v, e);
      put_bit(1'b1);
      check("R7 released after nack", sda_oe, 0);
      get_bit(a);
      check("R7 idle bit after nack", a, 1);
      check_flags("R7 still in access");
      bus_stop();
      mdl_close();
      check_flags("R9 after read stop");

      // R6 underrun then repeated START into write
      bus_start();
      put_byte({OWN, 1'b1}, a);
      mdl_match(1);
      check("R6 address ack", a, 0);
      e = mdl_take();
      get_bits(v);
      check("R6 filler byte", v, e);
      check_flags("R6 underrun set");
      put_bit(1'b1);
      bus_rstart();
      mdl_close();
      check_flags("R8 R9 repeated start");
      put_byte({OWN, 1'b0}, a);
      mdl_match(0);
      check("R2 ack after rstart", a, 0);
      check_flags("R6 R9 cleared by match");
      put_byte(8'h11, a);
      check("R4 rx after rstart", rx_data, 8'h11);
      bus_stop();
      mdl_close();
      pulse_rx_read();

      // R3 mismatch
      bus_start();
      put_byte({7'h15, 1'b0}, a);
      check("R3 address nack", a, 1);
      put_byte(8'h77, a);
      check("R3 data nack", a, 1);
      check("R3 rx_valid untouched", rx_valid, 0);
      check_flags("R3");
      bus_stop();
      check_flags("R3 R8 no eoa");

      // R10 disabled
      slave_en = 1'b0;
      bus_start();
      put_byte({OWN, 1'b0}, a);
      check("R10 no ack slave_en=0", a, 1);
      check_flags("R10 a");
      bus_stop();
      slave_en = 1'b1; master_dis = 1'b0;
      bus_start();
      put_byte({OWN, 1'b0}, a);
      check("R10 no ack master_dis=0", a, 1);
      check_flags("R10 b");
      bus_stop();
      master_dis = 1'b1;
      tick(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule